// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. An active-low start strobe, which may be far shorter than a clock period, is caught asynchronously and brought into the master-clock domain. Each conversion is a fixed run of clock cycles. The block first switches the track/hold into hold. It then works out the result one bit per cycle, from the most significant bit down. On each trial it puts a code on the internal DAC and keeps or clears the trial bit according to the comparator. Last, it loads the parallel result register and drops BUSY.

The result register drives a 12-bit parallel bus. A separate enable output gates the pad drivers and is active only while both active-low strobes, select and read, are low. The two strobes are interchangeable. If the start strobe is still low when a conversion finishes, the block powers down. The next rising edge of the strobe starts a parameterised wake-up delay. A start falling edge that arrives during that delay is held and served once the delay ends.

All pins are plain control, status and data levels. There is no valid/ready handshake and no back-pressure. The host reads the result register at any time through the select and read strobes, and the register keeps its value until the next conversion replaces it.

Top module: `sar_ctrl`

## Requirements
- R1: A falling edge on `start_n_i`, including a pulse shorter than one clock period, raises `busy_o` on the third rising clock edge after the edge (two synchronizer stages plus one decision register).
- R2: `busy_o` stays high for exactly WIDTH+2 clock cycles (14 at the default width): one hold cycle, WIDTH trial cycles and one load cycle.
- R3: The first trial code on `trial_code_o` has only the MSB (bit WIDTH-1) set. `cmp_keep_i`=1 keeps the current trial bit and 0 clears it, and the next lower bit is then set. With a comparator that keeps when the input is at least the trial code, the result is the input as straight binary, 0 to 4095.
- R4: `th_hold_o` is high in every busy cycle except the last one, and low whenever `busy_o` is low.
- R5: `result_o` takes the new value at the start of the last busy cycle, one cycle before `busy_o` falls. At all other times it keeps the previous result, including through the earlier cycles of a new conversion.
- R6: A falling edge on `start_n_i` while `busy_o` is high is ignored: that conversion still lasts WIDTH+2 cycles and no second conversion follows.
- R7: `result_oe_o` is high exactly when `sel_n_i` and `rd_n_i` are both low, so either strobe can gate the bus. With both tied low, the new result is enabled on the bus before `busy_o` falls.
- R8: If `start_n_i` is still low when a conversion ends, `pwrdn_o` rises in the same cycle that `busy_o` falls and stays high while the strobe remains low. Otherwise `pwrdn_o` stays low.
- R9: In power-down, a rising edge on `start_n_i` starts a wake-up of WAKE_CYCLES cycles. `pwrdn_o` falls on the (WAKE_CYCLES+3)th rising clock edge after the strobe edge, and the rising edge alone starts no conversion.
- R10: A start falling edge that arrives during the wake-up interval is held. `busy_o` rises on the (WAKE_CYCLES+4)th rising clock edge after the waking edge.
- R11: After reset, `busy_o`, `th_hold_o` and `pwrdn_o` are low and `result_o` and `trial_code_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master conversion clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| start_n_i | input | 1 | Active-low conversion start strobe; level at end of conversion selects power-down |
| sel_n_i | input | 1 | Active-low output select strobe |
| rd_n_i | input | 1 | Active-low read strobe |
| cmp_keep_i | input | 1 | Comparator decision: 1 keeps the current trial bit |
| th_hold_o | output | 1 | Track/hold control: 1 = hold, 0 = track |
| busy_o | output | 1 | High for the whole conversion |
| pwrdn_o | output | 1 | High while powered down or waking up |
| trial_code_o | output | WIDTH | Trial code for the internal DAC |
| result_o | output | WIDTH | Result register, straight binary |
| result_oe_o | output | 1 | Output-driver enable for the result bus |

## Verification
The bench sweeps every input code from 0 to 4095 with a comparator model built from the DAC code. A wrong bit order or a wrong keep/clear decision therefore shows up as a wrong result for some code, and an off-by-one bit counter shows up as a BUSY run that is not 14 cycles long. It sends start pulses shorter than a clock period, which a purely sampled start input would miss. It also checks that the previous result stays in the register until the final busy cycle, so a register loaded too early is caught. Further runs pulse the start strobe in the middle of a conversion, which a design that does not ignore it answers with a second conversion. The remaining runs hold the strobe low through the end of conversion and then release it, once alone and once with a new start during wake-up. These count the power-down and wake-up cycles exactly, so a design that drops a start held off during wake-up, or that starts converting on the waking edge, gets the wrong count.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [2:0] {
    ST_TRACK,
    ST_HOLD,
    ST_TRIAL,
    ST_LOAD,
    ST_SLEEP,
    ST_WAKE
  } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) sh_q <= {STAGES{RST_VAL}};
    else          sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/sar_edge_flag.sv
// Catches one edge of an asynchronous strobe, however short, by flipping a
// toggle clocked by the strobe itself, then brings the toggle into clk_i.
module sar_edge_flag #(
  parameter bit RISING = 1'b0,
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic pin_i,
  output logic tgl_o
);
  logic tgl_q;

  generate
    if (RISING) begin : g_rise
      always_ff @(posedge pin_i or negedge rst_n_i) begin
        if (!rst_n_i) tgl_q <= 1'b0;
        else          tgl_q <= ~tgl_q;
      end
    end else begin : g_fall
      always_ff @(negedge pin_i or negedge rst_n_i) begin
        if (!rst_n_i) tgl_q <= 1'b0;
        else          tgl_q <= ~tgl_q;
      end
    end
  endgenerate

  sar_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .d_i     (tgl_q),
    .q_o     (tgl_o)
  );
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import sar_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int WAKE_CYCLES = 10
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             fall_tgl_i,
  input  logic             rise_tgl_i,
  input  logic             start_low_i,
  input  logic             cmp_keep_i,
  output logic             busy_o,
  output logic             hold_o,
  output logic             pwrdn_o,
  output logic [WIDTH-1:0] trial_code_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int IDXW = $clog2(WIDTH);
  localparam int WCW  = $clog2(WAKE_CYCLES + 1);
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e       state_q;
  logic [IDXW-1:0]  idx_q;
  logic [WIDTH-1:0] trial_q, result_q;
  logic [WCW-1:0]   wake_q;
  logic             fall_seen_q, rise_seen_q;

  logic [WIDTH-1:0] bit_mask, decided, next_probe;

  always_comb begin
    bit_mask   = WIDTH'(1) << idx_q;
    decided    = cmp_keep_i ? trial_q : (trial_q & ~bit_mask);
    next_probe = decided | (bit_mask >> 1);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q     <= ST_TRACK;
      idx_q       <= '0;
      trial_q     <= '0;
      result_q    <= '0;
      wake_q      <= '0;
      fall_seen_q <= 1'b0;
      rise_seen_q <= 1'b0;
    end else begin
      // a rising edge only matters once asleep; earlier ones are consumed
      rise_seen_q <= rise_tgl_i;
      unique case (state_q)
        ST_TRACK: begin
          if (fall_tgl_i != fall_seen_q) begin
            fall_seen_q <= fall_tgl_i;
            state_q     <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          fall_seen_q <= fall_tgl_i;
          trial_q     <= MSB_ONLY;
          idx_q       <= IDXW'(WIDTH - 1);
          state_q     <= ST_TRIAL;
        end
        ST_TRIAL: begin
          fall_seen_q <= fall_tgl_i;
          if (idx_q == '0) begin
            trial_q  <= decided;
            result_q <= decided;
            state_q  <= ST_LOAD;
          end else begin
            trial_q <= next_probe;
            idx_q   <= idx_q - 1'b1;
          end
        end
        ST_LOAD: begin
          fall_seen_q <= fall_tgl_i;
          state_q     <= start_low_i ? ST_SLEEP : ST_TRACK;
        end
        ST_SLEEP: begin
          if (rise_tgl_i != rise_seen_q) begin
            wake_q  <= WCW'(WAKE_CYCLES - 1);
            state_q <= ST_WAKE;
          end
        end
        ST_WAKE: begin
          // falling edges stay pending here and are served from ST_TRACK
          if (wake_q == '0) state_q <= ST_TRACK;
          else              wake_q  <= wake_q - 1'b1;
        end
        default: state_q <= ST_TRACK;
      endcase
    end
  end

  assign busy_o       = (state_q == ST_HOLD) || (state_q == ST_TRIAL) || (state_q == ST_LOAD);
  assign hold_o       = (state_q == ST_HOLD) || (state_q == ST_TRIAL);
  assign pwrdn_o      = (state_q == ST_SLEEP) || (state_q == ST_WAKE);
  assign trial_code_o = trial_q;
  assign result_o     = result_q;
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int WIDTH       = 12,
  parameter int WAKE_CYCLES = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             start_n_i,
  input  logic             sel_n_i,
  input  logic             rd_n_i,
  input  logic             cmp_keep_i,
  output logic             th_hold_o,
  output logic             busy_o,
  output logic             pwrdn_o,
  output logic [WIDTH-1:0] trial_code_o,
  output logic [WIDTH-1:0] result_o,
  output logic             result_oe_o
);
  logic fall_tgl, rise_tgl, start_lvl;

  sar_edge_flag #(.RISING(1'b0), .STAGES(SYNC_STAGES)) u_fall (
    .clk_i (clk_i), .rst_n_i (rst_n_i), .pin_i (start_n_i), .tgl_o (fall_tgl)
  );

  sar_edge_flag #(.RISING(1'b1), .STAGES(SYNC_STAGES)) u_rise (
    .clk_i (clk_i), .rst_n_i (rst_n_i), .pin_i (start_n_i), .tgl_o (rise_tgl)
  );

  sar_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_lvl (
    .clk_i (clk_i), .rst_n_i (rst_n_i), .d_i (start_n_i), .q_o (start_lvl)
  );

  sar_sequencer #(.WIDTH(WIDTH), .WAKE_CYCLES(WAKE_CYCLES)) u_seq (
    .clk_i        (clk_i),
    .rst_n_i      (rst_n_i),
    .fall_tgl_i   (fall_tgl),
    .rise_tgl_i   (rise_tgl),
    .start_low_i  (~start_lvl),
    .cmp_keep_i   (cmp_keep_i),
    .busy_o       (busy_o),
    .hold_o       (th_hold_o),
    .pwrdn_o      (pwrdn_o),
    .trial_code_o (trial_code_o),
    .result_o     (result_o)
  );

  // both strobes feed one AND of their active-low states
  assign result_oe_o = ~sel_n_i & ~rd_n_i;
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk_i,
  input logic             rst_n_i,
  input logic             th_hold_o,
  input logic             busy_o,
  input logic             pwrdn_o,
  input logic [WIDTH-1:0] trial_code_o,
  input logic [WIDTH-1:0] result_o
);
  localparam int TOTAL = WIDTH + 2;
  localparam int CW    = $clog2(TOTAL + 1) + 1;
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  logic [CW-1:0] busy_run_q;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)    busy_run_q <= '0;
    else if (busy_o) busy_run_q <= busy_run_q + 1'b1;
    else             busy_run_q <= '0;
  end

  // R2: every busy run lasts exactly WIDTH+2 cycles
  p_busy_len_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $fell(busy_o) |-> busy_run_q == CW'(TOTAL));

  // R3: the first trial after the hold cycle carries only the MSB
  p_msb_first_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(busy_o) |=> trial_code_o == MSB_ONLY);

  // R4: hold only inside a conversion
  p_hold_in_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    th_hold_o |-> busy_o);

  // R5: the result changes only in the last busy cycle, already tracking
  p_result_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !$stable(result_o) |-> (busy_o && !th_hold_o));

  // R8: power-down begins only as a conversion ends
  p_sleep_entry_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(pwrdn_o) |-> $fell(busy_o));

  // R9: no conversion activity while powered down or waking
  p_sleep_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    pwrdn_o |-> (!busy_o && !th_hold_o));
endmodule

bind sar_ctrl sar_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i        (clk_i),
  .rst_n_i      (rst_n_i),
  .th_hold_o    (th_hold_o),
  .busy_o       (busy_o),
  .pwrdn_o      (pwrdn_o),
  .trial_code_o (trial_code_o),
  .result_o     (result_o)
);

// File: tb/sim_sar_ctrl.sv
module sim_sar_ctrl;
  localparam int W  = 12;
  localparam int WK = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_n = 1'b1, sel_n = 1'b1, rd_n = 1'b1;
  logic [W-1:0] vin = '0;
  logic [W-1:0] last_res = '0;
  logic hold, busy, pwrdn, oe, cmp;
  logic [W-1:0] trial, result;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  assign cmp = (vin >= trial);

  always #10 clk = ~clk;

  sar_ctrl #(.WIDTH(W), .WAKE_CYCLES(WK)) u0 (
    .clk_i (clk), .rst_n_i (rst_n), .start_n_i (start_n), .sel_n_i (sel_n),
    .rd_n_i (rd_n), .cmp_keep_i (cmp), .th_hold_o (hold), .busy_o (busy),
    .pwrdn_o (pwrdn), .trial_code_o (trial), .result_o (result), .result_oe_o (oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one conversion of code v; hold_low keeps start low afterwards,
  // poke pulses start in the middle of the busy run
  task automatic conv(input int v, input bit hold_low, input bit poke);
    int n, bc;
    bit ok_hold, ok_keep;
    logic [W-1:0] vv, exp3;
    vv = W'(v);
    exp3 = (vv & (W'(1) << (W-1))) | (W'(1) << (W-2));
    @(negedge clk);
    vin = vv;
    #2 start_n = 1'b0;
    if (!hold_low) #10 start_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (!busy && n < 40);
    chk(n == 3, "R1 busy rise edge", n, 3);
    bc = 0; ok_hold = 1'b1; ok_keep = 1'b1;
    while (busy && bc < 40) begin
      bc++;
      if (bc == 2) chk(trial == (W'(1) << (W-1)), "R3 first trial MSB", int'(trial), 1 << (W-1));
      if (bc == 3) chk(trial == exp3, "R3 second trial", int'(trial), int'(exp3));
      if (bc < W + 2) begin
        if (!hold) ok_hold = 1'b0;
        if (result != last_res) ok_keep = 1'b0;
      end else if (bc == W + 2) begin
        chk(!hold, "R4 track in last busy cycle", int'(hold), 0);
        chk(result == vv, "R5 result before busy falls", int'(result), v);
        chk(oe == (!sel_n && !rd_n), "R7 bus enabled with result", int'(oe), int'(!sel_n && !rd_n));
      end
      if (poke && bc == 5) begin #2 start_n = 1'b0; #10 start_n = 1'b1; end
      @(negedge clk);
    end
    chk(bc == W + 2, "R2 busy length", bc, W + 2);
    chk(ok_hold, "R4 hold through trials", int'(ok_hold), 1);
    chk(ok_keep, "R5 previous result kept", int'(ok_keep), 1);
    chk(result == vv, "R3 result value", int'(result), v);
    chk(pwrdn == hold_low, "R8 power-down at busy fall", int'(pwrdn), int'(hold_low));
    last_res = vv;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    bit quiet;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !hold && !pwrdn, "R11 reset outputs low", int'({busy, hold, pwrdn}), 0);
    chk(result == '0 && trial == '0, "R11 reset codes zero", int'(result), 0);

    // R7: every strobe combination
    for (int c = 0; c < 4; c++) begin
      sel_n = c[0]; rd_n = c[1];
      #1;
      chk(oe == (c == 0), "R7 enable from strobes", int'(oe), int'(c == 0));
    end

    // R3/R5/R7: full sweep with both strobes tied low
    sel_n = 1'b0; rd_n = 1'b0;
    for (int v = 0; v < (1 << W); v++) conv(v, 1'b0, 1'b0);

    // R6: start pulse while busy is ignored
    conv(1234, 1'b0, 1'b1);
    quiet = 1'b1;
    repeat (20) begin @(negedge clk); if (busy) quiet = 1'b0; end
    chk(quiet, "R6 no second conversion", int'(!quiet), 0);
    chk(result == W'(1234), "R6 result unchanged", int'(result), 1234);

    // R8/R9: sleep, stay asleep, then wake alone
    conv(77, 1'b1, 1'b0);
    quiet = 1'b1;
    repeat (10) begin @(negedge clk); if (!pwrdn || busy) quiet = 1'b0; end
    chk(quiet, "R8 stays powered down", int'(quiet), 1);
    #2 start_n = 1'b1;
    n = 0;
    do begin @(negedge clk); n++; end while (pwrdn && n < 50);
    chk(n == WK + 3, "R9 wake-up length", n, WK + 3);
    repeat (6) @(negedge clk);
    chk(!busy && !pwrdn, "R9 waking edge starts nothing", int'({busy, pwrdn}), 0);

    // R10: start during wake-up is held off
    conv(500, 1'b1, 1'b0);
    @(negedge clk);
    #2 start_n = 1'b1;
    n = 0;
    repeat (3) begin @(negedge clk); n++; end
    #2 start_n = 1'b0;
    #10 start_n = 1'b1;
    do begin @(negedge clk); n++; end while (!busy && n < 50);
    chk(n == WK + 4, "R10 held start after wake", n, WK + 4);
    while (busy) @(negedge clk);
    chk(result == W'(500) && !pwrdn, "R10 conversion completes awake", int'(result), 500);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule